// File: doc/BRIEF.md
# Segment Verification Gate Table

This controller sits between a datapath that has been split into a fixed number of execution segments and a trusted satisfiability checker. It keeps one "proven" flag per segment. A requester presents the set of segments it wants to run next as a bit mask. If every segment in that set is already proven, the request passes straight through with no stall. Otherwise the controller raises a stall. It then hands the unproven segments to the checker one at a time, lowest index first, and waits for a verdict on each.

A passing verdict marks the segment as proven. The stall is released only once every pending segment in the set has passed. A failing verdict locks that segment: its enable bit drops and its output lanes are forced to zero by an AND gate. The lock holds until a hard reset. Checks still pending in the same batch are dropped, and any request that includes a locked segment stays stalled for good. A separate clear input wipes the proven flags so that every segment must be proven again. This clear leaves the locks in place.

Top module: `seg_gate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all proven flags are 0, every bit of `seg_en` is 1, `chk_start` is 0, and `stall` is 0 while `req_valid` is 0.
- R2: A request whose mask holds only proven segments sees `stall` low in the same cycle, and no check is started.
- R3: A request whose mask holds an unproven, unlocked segment drives `stall` high in the same cycle. `chk_start` pulses for one cycle on the next cycle.
- R4: Pending checks are issued one at a time in ascending index order, and segments that are already proven are skipped. Each `chk_start` after the first comes one cycle after the passing `chk_done` of the previous check. `chk_seg` carries the binary index of the segment being checked.
- R5: A passing verdict (`chk_done`=1, `chk_sat`=1) sets that segment's flag. `stall` falls the cycle after the last pending check passes. A later request for that segment is not stalled.
- R6: A failing verdict (`chk_done`=1, `chk_sat`=0) clears that segment's `seg_en` bit and drops the checks still pending. `stall` stays high while the request is held.
- R7: A lock stays in place until `rst_n` is asserted, and `tbl_clear` does not remove it.
- R8: A request that includes a locked segment holds `stall` high and never starts the checker.
- R9: `tbl_clear` clears every proven flag on the next edge. This takes priority over a pass in the same cycle, so a later request for a cleared segment is checked again.
- R10: `chk_done` is ignored unless a check is outstanding, and it sets no flag when ignored.
- R11: Output lane i (bits i*DATA_W and up, DATA_W wide) of `seg_dout` equals the same lane of `seg_din` ANDed with `seg_en[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears flags and locks |
| tbl_clear | input | 1 | Clears all proven flags, keeps locks |
| req_valid | input | 1 | A set of next segments is requested |
| req_mask | input | NUM_SEG | Bit i set: segment i is in the request |
| stall | output | 1 | Hold execution; request is not yet granted |
| chk_start | output | 1 | One-cycle pulse starting a check |
| chk_seg | output | IDX_W | Index of the segment under check |
| chk_done | input | 1 | Checker verdict valid |
| chk_sat | input | 1 | Verdict: 1 proof satisfiable, 0 not |
| seg_en | output | NUM_SEG | Per-segment enable, 0 when locked |
| seg_din | input | NUM_SEG*DATA_W | Raw segment output lanes |
| seg_dout | output | NUM_SEG*DATA_W | Lanes gated by the segment enables |

## Verification
The hardest case to reach from the ports is a failing verdict in the middle of a batch. The earlier segments in that batch are already proven, the later ones are still pending, and they must never be issued. The bench reaches it with a mask mixing proven and unproven segments, plus a checker model whose verdict per segment is preset so that the middle one fails. The bench then counts start pulses and confirms that none follows. Verdicts that arrive while no check is outstanding are also produced on purpose by the checker model. Afterwards a fresh request shows that the stray verdict proved nothing.

// File: rtl/seg_gate_pkg.sv
// Shared types for the segment verification gate.
package seg_gate_pkg;
    // Controller sequencing states
    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_ISSUE = 2'd1,
        GS_WAIT  = 2'd2
    } gate_state_t;
endpackage

// File: rtl/seg_lowest_pick.sv
// Lowest-set-bit picker.
// Does: returns the index of the least significant set bit of vec.
// Assumes: idx is meaningless when any_set is 0.
module seg_lowest_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any_set
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx     = '0;
        any_set = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx     = W'(i);
                any_set = 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_flag_table.sv
// Per-segment proven/locked table.
// Does: holds one proven bit and one lock bit per segment.
// Assumes: set and lock never target the same cycle (controller guarantees);
// clear_all wipes proven bits only and wins over a set in the same cycle.
module seg_flag_table #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_all,
    input  logic         set_en,
    input  logic [W-1:0] set_idx,
    input  logic         lock_en,
    input  logic [W-1:0] lock_idx,
    output logic [N-1:0] ver_q,
    output logic [N-1:0] lock_q
);
    // Proven flags: reset/clear to 0, set on a pass
    always_ff @(posedge clk) begin
        if (!rst_n)         ver_q <= '0;
        else if (clear_all) ver_q <= '0;
        else if (set_en)    ver_q[set_idx] <= 1'b1;
    end

    // Lock flags: sticky until hard reset
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= '0;
        else if (lock_en) lock_q[lock_idx] <= 1'b1;
    end

    // A segment is never both proven and locked (R6)
    assert_proven_not_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ver_q & lock_q) == '0);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_sticky
            // Lock bits never fall while out of reset (R7)
            assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[g] |=> lock_q[g]);
        end
    endgenerate
endmodule

// File: rtl/seg_out_lock.sv
// Output lane gating.
// Does: ANDs each segment's output lane with that segment's enable.
// Assumes: lanes are packed with segment 0 in the least significant bits.
module seg_out_lock #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic [N-1:0]    en,
    input  logic [N*DW-1:0] din,
    output logic [N*DW-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_lane
            // One AND gate bank per segment lane
            assign dout[g*DW +: DW] = din[g*DW +: DW] & {DW{en[g]}};
        end
    endgenerate
endmodule

// File: rtl/seg_gate_ctrl.sv
// Segment verification gate controller (top).
// Does: stalls requests touching unproven segments, runs their checks one at
// a time in ascending order, records passes, locks failures and gates lanes.
// Assumes: requester holds req_valid/req_mask stable until stall is low;
// the checker answers each chk_start with exactly one chk_done.
module seg_gate_ctrl #(
    parameter int NUM_SEG = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int BUS_W  = NUM_SEG * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_clear,
    input  logic               req_valid,
    input  logic [NUM_SEG-1:0] req_mask,
    output logic               stall,
    output logic               chk_start,
    output logic [IDX_W-1:0]   chk_seg,
    input  logic               chk_done,
    input  logic               chk_sat,
    output logic [NUM_SEG-1:0] seg_en,
    input  logic [BUS_W-1:0]   seg_din,
    output logic [BUS_W-1:0]   seg_dout
);
    import seg_gate_pkg::*;

    gate_state_t        state_q;
    logic [NUM_SEG-1:0] pend_q;
    logic [IDX_W-1:0]   cur_q;
    logic [NUM_SEG-1:0] ver_q;
    logic [NUM_SEG-1:0] lock_q;
    logic [NUM_SEG-1:0] pend_new;
    logic               blocked;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;
    logic               pass_ev;
    logic               fail_ev;

    seg_flag_table #(.N(NUM_SEG), .W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clear_all(tbl_clear),
        .set_en(pass_ev), .set_idx(cur_q),
        .lock_en(fail_ev), .lock_idx(cur_q),
        .ver_q(ver_q), .lock_q(lock_q)
    );

    seg_lowest_pick #(.N(NUM_SEG), .W(IDX_W)) u_pick (
        .vec(pend_q), .idx(pick_idx), .any_set(pick_any)
    );

    seg_out_lock #(.N(NUM_SEG), .DW(DATA_W)) u_lock (
        .en(seg_en), .din(seg_din), .dout(seg_dout)
    );

    // Request decode: which requested segments still need a proof
    always_comb begin
        pend_new = req_mask & ~ver_q;
        blocked  = |(req_mask & lock_q);
    end

    // Verdict decode: only honoured while a check is outstanding
    always_comb begin
        pass_ev = (state_q == GS_WAIT) && chk_done && chk_sat;
        fail_ev = (state_q == GS_WAIT) && chk_done && !chk_sat;
    end

    // Sequencer: latch pending set, issue checks, consume verdicts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            pend_q  <= '0;
            cur_q   <= '0;
        end else begin
            case (state_q)
                GS_IDLE: begin
                    if (req_valid && !blocked && (|pend_new)) begin
                        pend_q  <= pend_new;
                        state_q <= GS_ISSUE;
                    end
                end
                GS_ISSUE: begin
                    cur_q            <= pick_idx;
                    pend_q[pick_idx] <= 1'b0;
                    state_q          <= GS_WAIT;
                end
                GS_WAIT: begin
                    if (chk_done) begin
                        if (chk_sat && (|pend_q)) begin
                            state_q <= GS_ISSUE;
                        end else begin
                            pend_q  <= '0;
                            state_q <= GS_IDLE;
                        end
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    // Outputs: stall, checker handshake and enables
    always_comb begin
        stall     = (state_q != GS_IDLE) || (req_valid && (|pend_new));
        chk_start = (state_q == GS_ISSUE);
        chk_seg   = (state_q == GS_ISSUE) ? pick_idx : cur_q;
        seg_en    = ~lock_q;
    end

    // Start is a single-cycle pulse, one check at a time (R4)
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |=> !chk_start);

    // A started check always targets an unproven segment (R4)
    assert_start_unproven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |-> !ver_q[chk_seg]);

    // Next check in a batch follows a pass with a higher index (R4)
    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_WAIT && chk_done && chk_sat && (|pend_q))
        |=> (chk_start && (chk_seg > $past(cur_q))));

    // The checker only runs while the requester is held (R3)
    assert_start_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |-> stall);

    // A request touching a locked segment is never granted (R8)
    assert_locked_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (|(req_mask & ~seg_en))) |-> stall);

    // A failing verdict ends the batch with no further start (R6)
    assert_fail_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_ev |=> !chk_start);
endmodule

// File: tb/sim_seg_gate_ctrl.sv
// Scoreboard bench: driver queues expected check indices, checker model
// pops and compares them as starts appear, and answers with preset verdicts.
module sim_seg_gate_ctrl;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int W  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tbl_clear = 1'b0;
    logic          req_valid = 1'b0;
    logic [N-1:0]  req_mask = '0;
    logic          stall;
    logic          chk_start;
    logic [W-1:0]  chk_seg;
    logic          chk_done = 1'b0;
    logic          chk_sat = 1'b0;
    logic [N-1:0]  seg_en;
    logic [N*DW-1:0] seg_din = '0;
    logic [N*DW-1:0] seg_dout;

    int checks = 0;
    int failures = 0;
    int n_starts = 0;
    int exp_q[$];
    logic [N-1:0] sat_map = '1;
    logic spur_req = 1'b0;
    logic spur_sat = 1'b0;

    always #2 clk = ~clk;

    seg_gate_ctrl #(.NUM_SEG(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tbl_clear(tbl_clear),
        .req_valid(req_valid), .req_mask(req_mask), .stall(stall),
        .chk_start(chk_start), .chk_seg(chk_seg), .chk_done(chk_done),
        .chk_sat(chk_sat), .seg_en(seg_en), .seg_din(seg_din),
        .seg_dout(seg_dout)
    );

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Count start pulses
    always @(negedge clk) if (chk_start) n_starts++;

    // Monitor / checker model: compare starts with queue, then answer
    initial begin
        forever begin
            @(negedge clk);
            if (chk_start) begin
                int exp_i;
                int got;
                got = int'(chk_seg);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected start", got, -1);
                end else begin
                    exp_i = exp_q.pop_front();
                    check(got == exp_i, "R4 check order", got, exp_i);
                end
                step(2);
                chk_done = 1'b1;
                chk_sat  = sat_map[got];
                step(1);
                chk_done = 1'b0;
                chk_sat  = 1'b0;
            end else if (spur_req) begin
                step(0);
                @(posedge clk); #1;
                chk_done = 1'b1;
                chk_sat  = spur_sat;
                step(1);
                chk_done = 1'b0;
                chk_sat  = 1'b0;
                spur_req = 1'b0;
            end
        end
    end

    // Wait for the stall to drop, bounded
    task automatic wait_grant(output bit granted);
        granted = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!stall) begin
                granted = 1'b1;
                break;
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit g;
        int s0;
        for (int i = 0; i < N; i++) seg_din[i*DW +: DW] = DW'(8'hA0 + i);
        step(3);
        @(negedge clk);
        check(stall == 1'b0, "R1 stall after reset", stall, 0);
        check(seg_en == '1, "R1 enables after reset", seg_en, 8'hFF);
        check(chk_start == 1'b0, "R1 no start after reset", chk_start, 0);
        check(seg_dout == seg_din, "R11 lanes pass when enabled", seg_dout, seg_din);
        rst_n = 1'b1;
        step(2);

        // R3/R4/R5: segments 1 and 3 unproven, both pass
        exp_q.push_back(1); exp_q.push_back(3);
        req_valid = 1'b1; req_mask = 8'b0000_1010;
        @(negedge clk);
        check(stall == 1'b1, "R3 stall same cycle", stall, 1);
        @(negedge clk);
        check(chk_start == 1'b1, "R3 start next cycle", chk_start, 1);
        wait_grant(g);
        check(g, "R5 stall released after passes", g, 1);
        check(exp_q.size() == 0, "R4 all checks issued", exp_q.size(), 0);
        step(1);
        req_valid = 1'b0; req_mask = '0;
        step(2);

        // R2: proven set passes without stall or start
        s0 = n_starts;
        req_valid = 1'b1; req_mask = 8'b0000_1010;
        @(negedge clk);
        check(stall == 1'b0, "R2 no stall for proven set", stall, 0);
        step(5);
        check(n_starts == s0, "R2 no check for proven set", n_starts, s0);
        req_valid = 1'b0; req_mask = '0;
        step(2);

        // R4/R6: mask {0,1,2,5}; 1 proven; 2 fails so 5 is never issued
        sat_map = 8'b1111_1011;
        exp_q.push_back(0); exp_q.push_back(2);
        s0 = n_starts;
        req_valid = 1'b1; req_mask = 8'b0010_0111;
        step(30);
        @(negedge clk);
        check(n_starts == s0 + 2, "R6 remaining check dropped", n_starts, s0 + 2);
        check(exp_q.size() == 0, "R4 skip proven segment", exp_q.size(), 0);
        check(seg_en == 8'b1111_1011, "R6 failing segment disabled", seg_en, 8'hFB);
        check(stall == 1'b1, "R6 stall held after failure", stall, 1);
        check(seg_dout[2*DW +: DW] == '0, "R11 locked lane zero", seg_dout[2*DW +: DW], 0);
        check(seg_dout[3*DW +: DW] == seg_din[3*DW +: DW], "R11 other lane passes",
              seg_dout[3*DW +: DW], seg_din[3*DW +: DW]);
        step(1);
        req_valid = 1'b0; req_mask = '0;
        step(2);

        // R8: request including locked segment never starts checker
        s0 = n_starts;
        req_valid = 1'b1; req_mask = 8'b0000_0100;
        step(15);
        @(negedge clk);
        check(stall == 1'b1, "R8 locked request stalls", stall, 1);
        check(n_starts == s0, "R8 no solver restart", n_starts, s0);
        step(1);
        req_valid = 1'b0; req_mask = '0;
        step(2);

        // R5: segment 0 passed earlier, now runs without stall
        req_valid = 1'b1; req_mask = 8'b0000_0001;
        @(negedge clk);
        check(stall == 1'b0, "R5 passed segment stays proven", stall, 0);
        step(1);
        req_valid = 1'b0; req_mask = '0;

        // R9/R7: clear flags; lock stays; segment 0 rechecked
        tbl_clear = 1'b1;
        step(1);
        tbl_clear = 1'b0;
        step(1);
        @(negedge clk);
        check(seg_en[2] == 1'b0, "R7 clear keeps lock", seg_en[2], 0);
        // R10: stray pass while idle must not prove anything
        spur_sat = 1'b1; spur_req = 1'b1;
        step(6);
        exp_q.push_back(0);
        req_valid = 1'b1; req_mask = 8'b0000_0001;
        @(negedge clk);
        check(stall == 1'b1, "R9/R10 cleared segment stalls", stall, 1);
        wait_grant(g);
        check(g, "R9 recheck completes", g, 1);
        check(exp_q.size() == 0, "R10 stray done ignored, recheck issued", exp_q.size(), 0);
        step(1);
        req_valid = 1'b0; req_mask = '0;
        step(2);

        // R7: hard reset removes the lock
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        @(negedge clk);
        check(seg_en == '1, "R7 reset clears lock", seg_en, 8'hFF);
        check(seg_dout == seg_din, "R11 lanes restored", seg_dout, seg_din);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule